// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether an incoming Ethernet frame is kept or discarded, based only on its 48-bit destination address, a CRC-error flag that comes with the frame, and a small set of mode bits. A frame is presented as one valid strobe carrying the destination address. Exactly two clocks later the block returns a single decision strobe with an accept bit. Unicast frames are matched against a programmed station address. Broadcast frames are gated by their own mode bit. Multicast frames are either accepted wholesale or looked up in a 64-bit hash table, indexed by six bits of a CRC32 taken over the address.

The hash table can be loaded in two ways. A 16-bit configuration write port writes it one word at a time. A builder port clears it and then sets one bit for each multicast address presented on the port. The builder computes the CRC itself, so software only has to supply the group addresses. The configuration port also holds the mode register and the station address.

Addresses use wire order. Bits 47..40 hold the first byte on the wire, and bit 40 is the group (multicast) bit of that byte.

Top module: `rx_addr_filter`

## Requirements
- R1: For every cycle with `frameValid` high, `decValid` is high for one cycle exactly two rising edges later. `decAccept` is never high without `decValid`.
- R2: While bit 0 (receive start) of the mode register is clear, every frame is rejected.
- R3: When bit 1 (drop on CRC error) of the mode register is set, a frame presented with `frameCrcErr` high is rejected, even in promiscuous mode. When bit 1 is clear, the flag has no effect.
- R4: When bit 5 (promiscuous) is set, every frame is accepted, subject to R2 and R3.
- R5: The all-ones destination (broadcast) is accepted only when bit 2 (broadcast accept) is set, unless R4 applies. Bit 4 does not admit it.
- R6: A multicast destination (bit 40 set, not broadcast) is accepted when bit 4 (all-multicast) is set, whatever the hash table holds.
- R7: Otherwise, a multicast destination is accepted only if bit 3 (hash filter on) is set and table bit h is set. Here h is bits 31..26 of a CRC32 over the six address bytes: polynomial 0x04C11DB7, start value all ones, no final inversion, bytes in wire order, each byte least significant bit first, shifting toward bit 31.
- R8: A unicast destination (bit 40 clear) is accepted only when it equals the station address register, unless R4 applies.
- R9: Configuration writes go through `cfgAddr`. Address 0 is the mode register (bits 5..0). Addresses 1, 2 and 3 load station address bits 47..32, 31..16 and 15..0. Addresses 4 to 7 load table word k = addr-4, which holds table bits 16k+15..16k. Table bit h is bit h mod 8 of table byte h div 8.
- R10: `hashClear` zeroes the whole table. `hashAddValid` sets the table bit indexed by the CRC of `hashAddAddr` (R7) and leaves the other bits unchanged. When both are high in the same cycle, the table holds only the new bit. When an add and a table-word write fall in the same cycle, the added bit is ORed onto the written word.
- R11: After reset, the mode, station and table registers are zero and no decision strobe is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register select (R9) |
| cfgData | input | 16 | Configuration write data |
| hashClear | input | 1 | Clear the multicast hash table |
| hashAddValid | input | 1 | Add the address on hashAddAddr to the table |
| hashAddAddr | input | 48 | Multicast address to hash into the table |
| frameValid | input | 1 | Frame destination present |
| frameDest | input | 48 | Destination address, first wire byte in bits 47..40 |
| frameCrcErr | input | 1 | Frame carried a bad frame check sequence |
| decValid | output | 1 | Decision strobe, two clocks after frameValid |
| decAccept | output | 1 | Frame accepted when high with decValid |

## Verification
Directed frames run one address class at a time against one mode bit at a time: a matching and a non-matching unicast, the broadcast address, and multicast addresses whose hash bit is set or clear. This shows that each mode bit gates only its own class and that promiscuous mode still yields to the CRC-error drop. The hash path is tried twice, once through the builder and once with raw table-word writes. This tells a wrong CRC bit order or byte order apart from a wrong word-to-bit mapping. A long random mix of mode values, station hits, broadcast, multicast and CRC-error flags then exercises the priority between the rules.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
  // Frame geometry and register layout
  localparam int ADDR_W     = 48;
  localparam int CFG_W      = 16;
  localparam int HASH_BITS  = 6;
  localparam int TABLE_W    = 1 << HASH_BITS;
  localparam int STA_WORDS  = ADDR_W / CFG_W;
  localparam int HASH_WORDS = TABLE_W / CFG_W;
  localparam int STA_BASE   = 1;
  localparam int HASH_BASE  = STA_BASE + STA_WORDS;
  localparam int REG_COUNT  = HASH_BASE + HASH_WORDS;
  localparam int CFG_AW     = $clog2(REG_COUNT);
  localparam int MODE_W     = 6;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  // Mode bit positions
  localparam int MB_START = 0;
  localparam int MB_DROP  = 1;
  localparam int MB_BCAST = 2;
  localparam int MB_HASH  = 3;
  localparam int MB_ALLMC = 4;
  localparam int MB_PROM  = 5;

  // Strobes from control to datapath
  typedef struct packed {
    logic                  modeWe;
    logic [STA_WORDS-1:0]  staWe;
    logic [HASH_WORDS-1:0] hashWe;
    logic                  hashClr;
    logic                  hashAdd;
  } ctrl_strobes_t;

  // MSB-first CRC32 over the address bytes in wire order, each byte LSB first
  function automatic logic [HASH_BITS-1:0] hashIndex(input logic [ADDR_W-1:0] addr);
    logic [31:0] crc;
    logic        fb;
    crc = '1;
    for (int byteIdx = 0; byteIdx < ADDR_W / 8; byteIdx++) begin
      for (int bitIdx = 0; bitIdx < 8; bitIdx++) begin
        fb  = crc[31] ^ addr[ADDR_W - 8 - 8 * byteIdx + bitIdx];
        crc = {crc[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
      end
    end
    return crc[31 -: HASH_BITS];
  endfunction
endpackage

// File: rtl/rx_addr_filter_ctrl.sv
module rx_addr_filter_ctrl
  import rx_addr_filter_pkg::*;
(
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              hashClear,
  input  logic              hashAddValid,
  output ctrl_strobes_t     strobes
);
  always_comb begin
    strobes.modeWe  = cfgWe && (cfgAddr == CFG_AW'(0));
    strobes.hashClr = hashClear;
    strobes.hashAdd = hashAddValid;
  end

  for (genvar k = 0; k < STA_WORDS; k++) begin : g_sta
    assign strobes.staWe[k] = cfgWe && (cfgAddr == CFG_AW'(STA_BASE + k));
  end

  for (genvar k = 0; k < HASH_WORDS; k++) begin : g_hash
    assign strobes.hashWe[k] = cfgWe && (cfgAddr == CFG_AW'(HASH_BASE + k));
  end
endmodule

// File: rtl/rx_addr_filter_dp.sv
module rx_addr_filter_dp
  import rx_addr_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobes_t     strobes,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [ADDR_W-1:0] hashAddAddr,
  input  logic              frameValid,
  input  logic [ADDR_W-1:0] frameDest,
  input  logic              frameCrcErr,
  output logic              decValid,
  output logic              decAccept
);
  logic [MODE_W-1:0]    modeReg;
  logic [ADDR_W-1:0]    staReg;
  logic [TABLE_W-1:0]   tableReg;
  logic [TABLE_W-1:0]   addMask;
  logic [TABLE_W-1:0]   tableNext;

  // Stage 1 registers
  logic                 s1Valid;
  logic                 s1CrcErr;
  logic                 s1Bcast;
  logic                 s1Mcast;
  logic                 s1StaHit;
  logic [HASH_BITS-1:0] s1Hash;
  logic                 acceptNow;

  // Mode register
  always_ff @(posedge clk) begin
    if (!rstN) modeReg <= '0;
    else if (strobes.modeWe) modeReg <= cfgData[MODE_W-1:0];
  end

  // Station address, most significant word first
  for (genvar k = 0; k < STA_WORDS; k++) begin : g_sta
    always_ff @(posedge clk) begin
      if (!rstN) staReg[ADDR_W-1-CFG_W*k -: CFG_W] <= '0;
      else if (strobes.staWe[k]) staReg[ADDR_W-1-CFG_W*k -: CFG_W] <= cfgData;
    end
  end

  // Hash table: clear, then word write, then builder OR on top
  assign addMask = strobes.hashAdd ? (TABLE_W'(1) << hashIndex(hashAddAddr)) : '0;

  for (genvar k = 0; k < HASH_WORDS; k++) begin : g_tbl
    logic [CFG_W-1:0] baseWord;
    always_comb begin
      if (strobes.hashClr)        baseWord = '0;
      else if (strobes.hashWe[k]) baseWord = cfgData;
      else                        baseWord = tableReg[CFG_W*k +: CFG_W];
      tableNext[CFG_W*k +: CFG_W] = baseWord | addMask[CFG_W*k +: CFG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) tableReg <= '0;
    else       tableReg <= tableNext;
  end

  // Stage 1: classify the address and hash it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1CrcErr <= 1'b0;
      s1Bcast  <= 1'b0;
      s1Mcast  <= 1'b0;
      s1StaHit <= 1'b0;
      s1Hash   <= '0;
    end else begin
      s1Valid  <= frameValid;
      s1CrcErr <= frameCrcErr;
      s1Bcast  <= &frameDest;
      s1Mcast  <= frameDest[ADDR_W-8];
      s1StaHit <= (frameDest == staReg);
      s1Hash   <= hashIndex(frameDest);
    end
  end

  // Stage 2: apply the mode rules in priority order
  always_comb begin
    if (!modeReg[MB_START])                   acceptNow = 1'b0;
    else if (s1CrcErr && modeReg[MB_DROP])    acceptNow = 1'b0;
    else if (modeReg[MB_PROM])                acceptNow = 1'b1;
    else if (s1Bcast)                         acceptNow = modeReg[MB_BCAST];
    else if (s1Mcast)                         acceptNow = modeReg[MB_ALLMC] ||
                                                          (modeReg[MB_HASH] && tableReg[s1Hash]);
    else                                      acceptNow = s1StaHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
    end else begin
      decValid  <= s1Valid;
      decAccept <= s1Valid && acceptNow;
    end
  end

  // Decision strobe follows the frame strobe by two edges (R1)
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> ##2 decValid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(frameValid, 2));
  assert_accept_qual_R1: assert property (@(posedge clk) disable iff (!rstN)
    decAccept |-> decValid);
  // No acceptance without receive start (R2)
  assert_need_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    decAccept |-> $past(modeReg[MB_START]));
  // CRC-error frame never accepted when drop bit set (R3)
  assert_crc_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    decAccept |-> !$past(s1CrcErr && modeReg[MB_DROP]));
  // Clear empties the table (R10)
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.hashClr && !strobes.hashAdd) |=> (tableReg == '0));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              hashClear,
  input  logic              hashAddValid,
  input  logic [ADDR_W-1:0] hashAddAddr,
  input  logic              frameValid,
  input  logic [ADDR_W-1:0] frameDest,
  input  logic              frameCrcErr,
  output logic              decValid,
  output logic              decAccept
);
  ctrl_strobes_t strobes;

  rx_addr_filter_ctrl u_ctrl (
    .cfgWe        (cfgWe),
    .cfgAddr      (cfgAddr),
    .hashClear    (hashClear),
    .hashAddValid (hashAddValid),
    .strobes      (strobes)
  );

  rx_addr_filter_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .cfgData      (cfgData),
    .hashAddAddr  (hashAddAddr),
    .frameValid   (frameValid),
    .frameDest    (frameDest),
    .frameCrcErr  (frameCrcErr),
    .decValid     (decValid),
    .decAccept    (decAccept)
  );
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic        hashClear = 1'b0;
  logic        hashAddValid = 1'b0;
  logic [47:0] hashAddAddr = '0;
  logic        frameValid = 1'b0;
  logic [47:0] frameDest = '0;
  logic        frameCrcErr = 1'b0;
  logic        decValid;
  logic        decAccept;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state
  logic [5:0]  mMode  = '0;
  logic [47:0] mSta   = '0;
  logic [63:0] mTable = '0;

  always #5 clk = ~clk;

  rx_addr_filter uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .hashClear(hashClear), .hashAddValid(hashAddValid), .hashAddAddr(hashAddAddr),
    .frameValid(frameValid), .frameDest(frameDest), .frameCrcErr(frameCrcErr),
    .decValid(decValid), .decAccept(decAccept)
  );

  // Bit-stream CRC reference, returns bits 31..26
  function automatic logic [5:0] refHash(input logic [47:0] a);
    logic [31:0] c;
    logic        inBit;
    c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      inBit = a[47 - 8 * (n / 8) - 7 + (n % 8)];
      if (c[31] ^ inBit) c = (c << 1) ^ 32'h04C1_1DB7;
      else               c = c << 1;
    end
    return c[31:26];
  endfunction

  function automatic bit refAccept(input logic [47:0] d, input bit err);
    if (!mMode[0]) return 1'b0;
    if (err && mMode[1]) return 1'b0;
    if (mMode[5]) return 1'b1;
    if (d == 48'hFFFF_FFFF_FFFF) return mMode[2];
    if (d[40]) return mMode[4] || (mMode[3] && mTable[refHash(d)]);
    return d == mSta;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (a == 3'd0) mMode = d[5:0];
    else if (a <= 3'd3) mSta[47 - 16 * (a - 1) -: 16] = d;
    else mTable[16 * (a - 4) +: 16] = d;
  endtask

  task automatic setMode(input logic [5:0] m);
    cfgWrite(3'd0, {10'd0, m});
  endtask

  task automatic setStation(input logic [47:0] s);
    cfgWrite(3'd1, s[47:32]);
    cfgWrite(3'd2, s[31:16]);
    cfgWrite(3'd3, s[15:0]);
  endtask

  task automatic builder(input bit clr, input bit add, input logic [47:0] a);
    @(negedge clk);
    hashClear = clr; hashAddValid = add; hashAddAddr = a;
    @(negedge clk);
    hashClear = 1'b0; hashAddValid = 1'b0;
    if (clr) mTable = '0;
    if (add) mTable[refHash(a)] = 1'b1;
  endtask

  // Drive one frame and check the decision two edges later
  task automatic sendFrame(input logic [47:0] d, input bit err, input string req);
    bit expAcc;
    expAcc = refAccept(d, err);
    @(negedge clk);
    frameValid = 1'b1; frameDest = d; frameCrcErr = err;
    @(negedge clk);
    frameValid = 1'b0; frameCrcErr = 1'b0;
    chk({req, "/R1 early"}, {63'd0, decValid}, 64'd0);
    @(negedge clk);
    chk({req, "/R1 valid"}, {63'd0, decValid}, 64'd1);
    chk(req, {63'd0, decAccept}, {63'd0, expAcc});
  endtask

  function automatic logic [47:0] randAddr();
    return {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
  endfunction

  initial begin
    logic [47:0] sta;
    logic [47:0] grpA;
    logic [47:0] grpB;
    logic [47:0] d;
    void'($urandom(32'd20240611));
    sta  = 48'h02_11_22_33_44_55;
    grpA = 48'h01_00_5E_00_00_01;
    grpB = 48'h33_33_00_00_00_FB;

    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 decValid", {63'd0, decValid}, 64'd0);
    chk("R11 decAccept", {63'd0, decAccept}, 64'd0);
    rstN = 1'b1;

    // R11/R2: zeroed mode rejects everything, including promiscuous-looking traffic
    sendFrame(48'hFFFF_FFFF_FFFF, 1'b0, "R2 bcast no start");
    sendFrame(48'h0, 1'b0, "R11 station zero but no start");

    // R5 broadcast gating
    setMode(6'b000101);
    sendFrame(48'hFFFF_FFFF_FFFF, 1'b0, "R5 bcast on");
    setMode(6'b010001);
    sendFrame(48'hFFFF_FFFF_FFFF, 1'b0, "R5 bcast off allmc");

    // R8 unicast station match, R9 station word order
    setStation(sta);
    setMode(6'b000001);
    sendFrame(sta, 1'b0, "R8 station hit");
    sendFrame(sta ^ 48'h1, 1'b0, "R8 station miss");
    sendFrame({sta[15:0], sta[47:16]}, 1'b0, "R9 word order");

    // R10 builder, R7 hash lookup
    setMode(6'b001001);
    builder(1'b1, 1'b0, '0);
    sendFrame(grpA, 1'b0, "R10 cleared table");
    builder(1'b0, 1'b1, grpA);
    sendFrame(grpA, 1'b0, "R7 built hit");
    sendFrame(grpB, 1'b0, "R7 other group");
    builder(1'b1, 1'b1, grpB);
    sendFrame(grpB, 1'b0, "R10 clear+add keeps new");
    sendFrame(grpA, 1'b0, "R10 clear+add drops old");
    setMode(6'b000001);
    sendFrame(grpB, 1'b0, "R7 hash filter off");

    // R9 direct word writes cover the whole table
    setMode(6'b001001);
    for (int k = 0; k < 4; k++) cfgWrite(3'(4 + k), 16'hFFFF);
    sendFrame(grpA, 1'b0, "R9 table all ones");
    for (int k = 0; k < 4; k++) cfgWrite(3'(4 + k), 16'h0000);
    sendFrame(grpB, 1'b0, "R9 table zero");
    cfgWrite(3'(4 + refHash(grpA) / 16), 16'(1) << (refHash(grpA) % 16));
    sendFrame(grpA, 1'b0, "R9 single bit word");

    // R10 add ORed onto a same-cycle word write
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 3'(4 + refHash(grpB) / 16); cfgData = 16'h0000;
    hashAddValid = 1'b1; hashAddAddr = grpB;
    @(negedge clk);
    cfgWe = 1'b0; hashAddValid = 1'b0;
    mTable[16 * (refHash(grpB) / 16) +: 16] = '0;
    mTable[refHash(grpB)] = 1'b1;
    sendFrame(grpB, 1'b0, "R10 add with word write");

    // R6 all-multicast ignores table
    builder(1'b1, 1'b0, '0);
    setMode(6'b010001);
    sendFrame(grpA, 1'b0, "R6 allmc empty table");
    sendFrame(randAddr() | 48'h0100_0000_0000, 1'b0, "R6 allmc random group");

    // R4 promiscuous, R3 crc drop
    setMode(6'b100001);
    sendFrame(48'h0A_0B_0C_0D_0E_0F, 1'b0, "R4 promisc unicast");
    sendFrame(48'h0A_0B_0C_0D_0E_0F, 1'b1, "R3 err flag ignored");
    setMode(6'b100011);
    sendFrame(48'h0A_0B_0C_0D_0E_0F, 1'b1, "R3 promisc err dropped");
    sendFrame(sta, 1'b1, "R3 station err dropped");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      if (it % 20 == 0) setMode(6'($urandom) | (($urandom % 8) != 0 ? 6'b1 : 6'b0));
      if (it % 50 == 0) builder(($urandom % 2) == 1, 1'b1, randAddr() | 48'h0100_0000_0000);
      case ($urandom % 4)
        0: d = 48'hFFFF_FFFF_FFFF;
        1: d = sta;
        2: d = randAddr() | 48'h0100_0000_0000;
        default: d = randAddr() & ~48'h0100_0000_0000;
      endcase
      sendFrame(d, ($urandom % 8) == 0, "R7 random mix");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule